// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Edge Interrupts

This block is a general-purpose I/O port of eight pins, controlled through a small register read/write bus. Each register holds one bit per pin. Software uses these registers to choose whether each pin drives or listens, to set the level it drives, and to read back the level present on the pad. A per-pin selection hands a pin over to an on-chip peripheral. When that selection is made, the peripheral's own output value and output enable take the place of the GPIO ones.

Every pin can also raise an interrupt. Each pad level first passes through a two-flop synchronizer. A chosen transition of the synchronized level (rising or falling, chosen per pin) sets a sticky flag for that pin. Software clears the flag by writing a one to its bit. The flags are masked by a per-pin enable and then ORed into a single interrupt line. A per-pin pull configuration bit is stored and can be read back, but it has no electrical effect inside the block.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads 0, `padOe` and `padOut` are 0 and `irq` is 0, so every pin is a GPIO input with interrupts disabled.
- R2: Register addresses are 0 input level (read-only), 1 output value, 2 direction (1 = output), 3 function select (1 = peripheral), 4 edge select, 5 interrupt enable, 6 interrupt flags, 7 pull configuration. Addresses 1 to 5 and 7 read back the last value written, and a write to address 0 changes nothing.
- R3: For a pin whose function-select bit is 0, `padOe` equals its direction bit and `padOut` equals its output-value bit.
- R4: For a pin whose function-select bit is 1, `padOut` equals `altOut` and `padOe` equals `altOe` for that pin.
- R5: The input register shows `padIn` delayed by exactly two clock edges, whatever the direction and function settings.
- R6: An edge-select bit of 0 makes a 0-to-1 change of the synchronized input set that pin's flag, and a 1 makes a 1-to-0 change set it. The flag reads set on the third clock edge after the pad changes. The opposite transition never sets the flag.
- R7: A flag stays set until a write of 1 to its bit at address 6. Bits written as 0 leave their flags unchanged.
- R8: If a new edge sets a flag in the same cycle as a clearing write to that bit, the flag stays set.
- R9: `irq` is high exactly when some pin has both its flag and its enable set. Flags are still set while their enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address for read and write |
| busWr | input | 1 | Write strobe, one write per high cycle |
| busWrData | input | 8 | Write data, one bit per pin |
| busRdData | output | 8 | Combinational read data of the addressed register |
| padIn | input | 8 | Pad levels seen by the port |
| padOut | output | 8 | Value driven toward the pads |
| padOe | output | 8 | Output enable toward the pads (1 = drive) |
| altOut | input | 8 | Peripheral output value per pin |
| altOe | input | 8 | Peripheral output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Several properties are checked on every cycle. The input register must follow the pad two edges later. A flag bit may rise only where the synchronized input has just changed. A flag may never drop without a write to the flag register. A direction write must appear on `padOe` when no pin is handed to a peripheral. The interrupt line may only rise after a flag or enable change. Other behaviour is shown only by the bench scenarios: the exact polarity of each edge mode per pin, the selective effect of clear masks, the collision between a clear and a new edge, and the per-bit mixing of peripheral and GPIO drive.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PINS   = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_IN   = 3'd0,
    ADDR_OUT  = 3'd1,
    ADDR_DIR  = 3'd2,
    ADDR_FUNC = 3'd3,
    ADDR_EDGE = 3'd4,
    ADDR_IEN  = 3'd5,
    ADDR_FLAG = 3'd6,
    ADDR_PULL = 3'd7
  } regAddrE;

  typedef struct packed {
    logic out;
    logic dir;
    logic func;
    logic edgeSel;
    logic ien;
    logic flagClr;
    logic pull;
  } wrStrobeT;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic                 busWr,
  input  logic [ADDR_BITS-1:0] busAddr,
  output wrStrobeT             strb
);
  always_comb begin
    strb = '0;
    if (busWr) begin
      case (regAddrE'(busAddr))
        ADDR_OUT:  strb.out     = 1'b1;
        ADDR_DIR:  strb.dir     = 1'b1;
        ADDR_FUNC: strb.func    = 1'b1;
        ADDR_EDGE: strb.edgeSel = 1'b1;
        ADDR_IEN:  strb.ien     = 1'b1;
        ADDR_FLAG: strb.flagClr = 1'b1;
        ADDR_PULL: strb.pull    = 1'b1;
        default:   strb         = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = PINS,
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobeT             strb,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [ADDR_BITS-1:0] rdAddr,
  output logic [PIN_COUNT-1:0] rdData,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic [PIN_COUNT-1:0] altOut,
  input  logic [PIN_COUNT-1:0] altOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic                 irq,
  output logic [PIN_COUNT-1:0] inVec,
  output logic [PIN_COUNT-1:0] flagVec,
  output logic [PIN_COUNT-1:0] enVec,
  output logic [PIN_COUNT-1:0] funcVec
);
  logic [PIN_COUNT-1:0] outQ, dirQ, funcQ, edgeQ, ienQ, flagQ, pullQ;
  logic [PIN_COUNT-1:0] syncA, syncB, prevQ;
  logic [PIN_COUNT-1:0] edgeHit, clrMask;

  assign clrMask = strb.flagClr ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= '0;
      dirQ  <= '0;
      funcQ <= '0;
      edgeQ <= '0;
      ienQ  <= '0;
      flagQ <= '0;
      pullQ <= '0;
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      if (strb.out)     outQ  <= wrData;
      if (strb.dir)     dirQ  <= wrData;
      if (strb.func)    funcQ <= wrData;
      if (strb.edgeSel) edgeQ <= wrData;
      if (strb.ien)     ienQ  <= wrData;
      if (strb.pull)    pullQ <= wrData;
      syncA <= padIn;
      syncB <= syncA;
      prevQ <= syncB;
      // a fresh edge wins over a clearing write
      flagQ <= (flagQ & ~clrMask) | edgeHit;
    end
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    assign edgeHit[i] = edgeQ[i] ? (prevQ[i] & ~syncB[i])
                                 : (~prevQ[i] & syncB[i]);
    assign padOut[i]  = funcQ[i] ? altOut[i] : outQ[i];
    assign padOe[i]   = funcQ[i] ? altOe[i]  : dirQ[i];
  end

  assign irq = |(flagQ & ienQ);

  always_comb begin
    case (regAddrE'(rdAddr))
      ADDR_IN:   rdData = syncB;
      ADDR_OUT:  rdData = outQ;
      ADDR_DIR:  rdData = dirQ;
      ADDR_FUNC: rdData = funcQ;
      ADDR_EDGE: rdData = edgeQ;
      ADDR_IEN:  rdData = ienQ;
      ADDR_FLAG: rdData = flagQ;
      ADDR_PULL: rdData = pullQ;
      default:   rdData = '0;
    endcase
  end

  assign inVec   = syncB;
  assign flagVec = flagQ;
  assign enVec   = ienQ;
  assign funcVec = funcQ;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = PINS,
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_BITS-1:0] busAddr,
  input  logic                 busWr,
  input  logic [PIN_COUNT-1:0] busWrData,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] altOut,
  input  logic [PIN_COUNT-1:0] altOe,
  output logic                 irq
);
  wrStrobeT             strb;
  logic [PIN_COUNT-1:0] inVec, flagVec, enVec, funcVec;

  gpio_port_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  gpio_port_dp #(.PIN_COUNT(PIN_COUNT), .ADDR_BITS(ADDR_BITS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWrData),
    .rdAddr  (busAddr),
    .rdData  (busRdData),
    .padIn   (padIn),
    .altOut  (altOut),
    .altOe   (altOe),
    .padOut  (padOut),
    .padOe   (padOe),
    .irq     (irq),
    .inVec   (inVec),
    .flagVec (flagVec),
    .enVec   (enVec),
    .funcVec (funcVec)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = PINS,
  parameter int ADDR_BITS = ADDR_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_BITS-1:0] busAddr,
  input logic                 busWr,
  input logic [PIN_COUNT-1:0] busWrData,
  input logic [PIN_COUNT-1:0] padIn,
  input logic [PIN_COUNT-1:0] padOe,
  input logic                 irq,
  input logic [PIN_COUNT-1:0] inVec,
  input logic [PIN_COUNT-1:0] flagVec,
  input logic [PIN_COUNT-1:0] enVec,
  input logic [PIN_COUNT-1:0] funcVec
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  a_r5_input_delay: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> inVec == $past(padIn, 2));

  a_r6_flag_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |->
      ((flagVec & ~$past(flagVec)) & ~($past(inVec) ^ $past(inVec, 2))) == '0);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && regAddrE'(busAddr) == ADDR_FLAG) |=>
      (flagVec & $past(flagVec)) == $past(flagVec));

  a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && regAddrE'(busAddr) == ADDR_DIR && funcVec == '0) |=>
      padOe == $past(busWrData));

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |->
      (($past(busWr) && regAddrE'($past(busAddr)) == ADDR_IEN) ||
       flagVec != $past(flagVec)));

  // enable vector is sampled for completeness of the interrupt view
  a_r9_irq_low_no_enable: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enVec) == '0 && !($past(busWr) && regAddrE'($past(busAddr)) == ADDR_IEN)) |-> !irq);
endmodule

bind gpio_port gpio_port_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_BITS(ADDR_BITS)) u_chk (.*);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] busAddr;
  logic       busWr;
  logic [7:0] busWrData, busRdData, padIn, padOut, padOe, altOut, altOe;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .altOut(altOut), .altOe(altOe), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic waitEdges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, expFlags, mask;
    rstN = 1'b0; busAddr = '0; busWr = 1'b0; busWrData = '0;
    padIn = '0; altOut = '0; altOe = '0;
    waitEdges(3);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 padOe", padOe, 8'h00);
    chk("R1 padOut", padOut, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    for (int a = 0; a < 8; a++) begin
      busRead(3'(a), rd);
      chk($sformatf("R1 reg %0d", a), rd, 8'h00);
    end

    // R2: readback of writable registers, input read-only
    for (int a = 1; a < 8; a++) begin
      if (a == 6) continue;
      busWrite(3'(a), 8'(8'h5A ^ (a * 17)));
      busRead(3'(a), rd);
      chk($sformatf("R2 readback %0d", a), rd, 8'(8'h5A ^ (a * 17)));
    end
    busWrite(3'd0, 8'hFF);
    busRead(3'd0, rd);
    chk("R2 input write ignored", rd, 8'h00);
    for (int a = 1; a < 8; a++) if (a != 6) busWrite(3'(a), 8'h00);

    // R3, R4: per-bit mix of GPIO and peripheral drive
    for (int k = 0; k < 16; k++) begin
      logic [7:0] o, d, f, ao, ae;
      o = 8'(k * 37); d = 8'(k * 91 + 3); f = 8'(k * 53 + 9);
      ao = ~8'(k * 29); ae = 8'(k * 13 + 5);
      altOut = ao; altOe = ae;
      busWrite(3'd1, o);
      busWrite(3'd2, d);
      busWrite(3'd3, f);
      #1;
      chk($sformatf("R3 R4 padOut k=%0d", k), padOut, (f & ao) | (~f & o));
      chk($sformatf("R3 R4 padOe k=%0d", k), padOe, (f & ae) | (~f & d));
    end
    busWrite(3'd3, 8'h00);
    busWrite(3'd2, 8'hFF);
    busWrite(3'd1, 8'hAA);

    // R5: input follows pad two edges later, even when driving
    for (int k = 0; k < 5; k++) begin
      logic [7:0] p, prev;
      busRead(3'd0, prev);
      p = 8'(k * 71 + 60);
      @(negedge clk); padIn = p;
      waitEdges(1);
      busRead(3'd0, rd);
      chk($sformatf("R5 one edge k=%0d", k), rd, prev);
      waitEdges(1);
      busRead(3'd0, rd);
      chk($sformatf("R5 two edges k=%0d", k), rd, p);
    end
    busWrite(3'd2, 8'h00);
    @(negedge clk); padIn = 8'h00;
    waitEdges(4);
    busWrite(3'd6, 8'hFF);

    // R6, R9: every pin in both edge modes
    mask = 8'hA5;
    busWrite(3'd5, mask);
    for (int mode = 0; mode < 2; mode++) begin
      logic [7:0] idle;
      idle = (mode == 1) ? 8'hFF : 8'h00;
      busWrite(3'd4, idle);
      @(negedge clk); padIn = idle;
      waitEdges(4);
      busWrite(3'd6, 8'hFF);
      busRead(3'd6, rd);
      chk($sformatf("R6 idle clear mode=%0d", mode), rd, 8'h00);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); padIn = idle ^ (8'h01 << i);
        waitEdges(2);
        busRead(3'd6, rd);
        chk($sformatf("R6 not yet mode=%0d pin=%0d", mode, i), rd, 8'h00);
        waitEdges(1);
        expFlags = 8'h01 << i;
        busRead(3'd6, rd);
        chk($sformatf("R6 flag mode=%0d pin=%0d", mode, i), rd, expFlags);
        chk($sformatf("R9 irq mode=%0d pin=%0d", mode, i), {7'b0, irq},
            {7'b0, |(expFlags & mask)});
        padIn = idle;
        waitEdges(4);
        busRead(3'd6, rd);
        chk($sformatf("R6 opposite edge mode=%0d pin=%0d", mode, i), rd, expFlags);
        busWrite(3'd6, expFlags);
        busRead(3'd6, rd);
        chk($sformatf("R7 clear mode=%0d pin=%0d", mode, i), rd, 8'h00);
      end
    end

    // R7: selective clear and zero writes
    busWrite(3'd4, 8'h00);
    @(negedge clk); padIn = 8'h00;
    waitEdges(4);
    busWrite(3'd6, 8'hFF);
    @(negedge clk); padIn = 8'hFF;
    waitEdges(4);
    busWrite(3'd6, 8'h00);
    busRead(3'd6, rd);
    chk("R7 zero write keeps flags", rd, 8'hFF);
    busWrite(3'd6, 8'h0F);
    busRead(3'd6, rd);
    chk("R7 partial clear", rd, 8'hF0);
    chk("R9 irq from upper flags", {7'b0, irq}, {7'b0, |(8'hF0 & mask)});
    busWrite(3'd5, 8'h0F);
    #1;
    chk("R9 disabled flags give no irq", {7'b0, irq}, 8'h00);
    busWrite(3'd5, mask);

    // R8: clear write in the same cycle as a new edge on that pin
    @(negedge clk); padIn = 8'h00;
    waitEdges(4);
    busWrite(3'd6, 8'hFF);
    @(negedge clk); padIn = 8'h08;
    waitEdges(4);
    busRead(3'd6, rd);
    chk("R8 setup flag", rd, 8'h08);
    padIn = 8'h00;
    waitEdges(4);
    padIn = 8'h08;
    waitEdges(2);
    busAddr = 3'd6; busWrData = 8'h08; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    busRead(3'd6, rd);
    chk("R8 edge wins over clear", rd, 8'h08);
    busWrite(3'd6, 8'h08);
    busRead(3'd6, rd);
    chk("R8 later clear works", rd, 8'h00);
    chk("R9 irq low after clear", {7'b0, irq}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule